// File: doc/BRIEF.md
# Pipelined Cascadable Parity Checker

This block checks a parity bit against a data word when that bit arrives one clock after the word. The parity of the low ten word bits is registered. One cycle later it is combined with the registered parity bit and with the level on a shared parity pin. The result is loaded into an error register on the following edge. The error indication therefore appears two clock edges after the word is sampled.

The shared parity pin has two roles. When its output enable input is high, the pin is an input. On a device used alone, its level selects even parity (0) or odd parity (1). On the second device of a cascaded pair, it carries the first device's partial sum. When its output enable input is low, the block drives the pin with its own partial sum so that a second checker can take it. Word bit 10 (zero-based) is also an active-low load enable for the error register. The error output is open-drain and is modelled as a single pull-low enable that a global output enable can switch off.

Top module: `cascade_parity_chk`

## Requirements
- R1: While `rst_n` is low at a rising edge, all pipeline and error state clears. From the next edge until a new result loads, `err_pull_o` is 0 (flag released).
- R2: Only bits [9:0] of `word_i` enter the parity sum. Bit 11 never changes the result. Bit 10 acts only as the load enable (R5).
- R3: A word sampled at edge k is paired with `par_i` sampled at edge k+1. Its result is loaded at edge k+2, using `par_pin_i` and `word_i[10]` sampled at edge k+2.
- R4: The loaded error value is the XOR of the ten word bits, the paired parity bit and `par_pin_i`. With the pin at 0, an even total of ones is clean. With the pin at 1, an odd total is clean.
- R5: When `word_i[10]` is 1 at an edge, the error register keeps its previous value at that edge. When it is 0, the register loads the new result.
- R6: When `par_oe_i` is 0, `par_pin_oe_o` is 1. `par_pin_o` then equals the XOR of the ten bits of the word sampled at edge k and the parity bit sampled at edge k+1, and holds that value from edge k+1 until edge k+2.
- R7: When `par_oe_i` is 1, `par_pin_oe_o` is 0 and the pin is not driven.
- R8: When `oe_n_i` is 1, `err_pull_o` is 0. The error register keeps loading, so after `oe_n_i` returns to 0 the flag shows the value loaded in the meantime.
- R9: `err_pull_o` is 1 exactly when the error register holds 1 and `oe_n_i` is 0. A 1 means the line is pulled low to flag an error. A released line reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| oe_n_i | input | 1 | Global output enable, active low, for the error line |
| word_i | input | 12 | Data word; [9:0] are checked, [10] is the active-low error load enable |
| par_i | input | 1 | Parity bit for the word of the previous cycle |
| par_oe_i | input | 1 | 1: parity pin is an input; 0: parity pin drives the partial sum |
| par_pin_i | input | 1 | Level on the parity pin: parity sense, or the cascaded partial sum |
| par_pin_o | output | 1 | Partial sum driven on the parity pin |
| par_pin_oe_o | output | 1 | Drive enable for the parity pin |
| err_pull_o | output | 1 | Open-drain pull-low enable for the error line |

## Verification
Two things can happen at the same edge: the error register taking a new result, and the load enable or the global output enable changing. The load enable arrives on a data bit, so the word sampled at that edge is also starting its own pass through the pipeline. The stimulus toggles `word_i[10]` and `oe_n_i` at random on the same edges that carry fresh words and parity bits. A reference pipeline in the bench decides, edge by edge, whether the flag should have loaded or held. In a directed sequence, an error is created while the output is disabled and must appear once the output enable returns. In another, a mismatch arrives while the load enable is off and the old clean flag must survive it.

// File: rtl/cpc_pkg.sv
// Shared types for the cascadable parity checker.
// Assumes a single clock domain and a synchronous active-low reset.
package cpc_pkg;

    // Registered state between the word stage and the error stage.
    typedef struct packed {
        logic word_sum;   // XOR of the checked bits of the previous word
        logic par_bit;    // parity bit paired with that word
    } fold_state_t;

endpackage

// File: rtl/cpc_word_stage.sv
// Word stage: samples the checked bits of the incoming word.
// Assumes CHK_W <= WORD_W; only the low CHK_W bits are kept.
module cpc_word_stage #(
    parameter int WORD_W = 12,
    parameter int CHK_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    output logic [CHK_W-1:0]  word_q
);

    // Capture the checked slice of the word on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_i[CHK_W-1:0];
    end

endmodule

// File: rtl/cpc_fold_stage.sv
// Fold stage: reduces the registered word to one bit and registers it
// next to the parity bit that arrives one cycle after the word.
// Assumes the parity bit is valid at the edge after its word.
module cpc_fold_stage
    import cpc_pkg::*;
#(
    parameter int CHK_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CHK_W-1:0] word_q,
    input  logic             par_i,
    output fold_state_t      fold_q
);

    logic [CHK_W-1:0] chain;

    // XOR chain over the checked bits, one stage per bit.
    assign chain[0] = word_q[0];
    for (genvar g = 1; g < CHK_W; g++) begin : g_chain
        assign chain[g] = chain[g-1] ^ word_q[g];
    end

    // Register the word sum and the parity bit together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fold_q <= '0;
        end else begin
            fold_q.word_sum <= chain[CHK_W-1];
            fold_q.par_bit  <= par_i;
        end
    end

endmodule

// File: rtl/cpc_flag_stage.sv
// Flag stage: loads the final check result into the error register when
// the active-low load enable is low; holds it otherwise.
// Assumes pin level and load enable are sampled at the loading edge.
module cpc_flag_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic partial_i,
    input  logic pin_i,
    input  logic load_n_i,
    output logic err_q
);

    // Update the error flag only when loading is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (!load_n_i) err_q <= partial_i ^ pin_i;
    end

endmodule

// File: rtl/cascade_parity_chk.sv
// Top of the cascadable parity checker. Word -> fold -> flag pipeline;
// the partial sum is driven on the parity pin when its enable is low,
// and the error line is an open-drain pull-low gated by oe_n_i.
// Assumes LOAD_BIT lies outside the checked slice.
module cascade_parity_chk
    import cpc_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int CHK_W    = 10,
    parameter int LOAD_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              par_i,
    input  logic              par_oe_i,
    input  logic              par_pin_i,
    output logic              par_pin_o,
    output logic              par_pin_oe_o,
    output logic              err_pull_o
);

    logic [CHK_W-1:0] word_q;
    fold_state_t      fold_q;
    logic             partial;
    logic             err_q;

    cpc_word_stage #(.WORD_W(WORD_W), .CHK_W(CHK_W)) u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (word_i),
        .word_q (word_q)
    );

    cpc_fold_stage #(.CHK_W(CHK_W)) u_fold (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_q (word_q),
        .par_i  (par_i),
        .fold_q (fold_q)
    );

    // Local partial sum: word parity folded with its parity bit.
    assign partial = fold_q.word_sum ^ fold_q.par_bit;

    cpc_flag_stage u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .partial_i (partial),
        .pin_i     (par_pin_i),
        .load_n_i  (word_i[LOAD_BIT]),
        .err_q     (err_q)
    );

    // Parity pin drive and open-drain error line.
    assign par_pin_o    = partial;
    assign par_pin_oe_o = ~par_oe_i;
    assign err_pull_o   = err_q & ~oe_n_i;

endmodule

// File: rtl/cpc_checker.sv
// Property checker for cascade_parity_chk, attached by bind.
module cpc_checker #(
    parameter int WORD_W   = 12,
    parameter int CHK_W    = 10,
    parameter int LOAD_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oe_n_i,
    input logic [WORD_W-1:0] word_i,
    input logic              par_i,
    input logic              par_oe_i,
    input logic              par_pin_i,
    input logic              par_pin_o,
    input logic              par_pin_oe_o,
    input logic              err_pull_o,
    input logic              err_q
);

    // R1: reset releases the flag
    assert_reset_release_R1: assert property (@(posedge clk)
        !rst_n |=> !err_pull_o);

    // R3 / R4: loaded value matches word, paired parity bit and pin
    assert_result_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && !$past(word_i[LOAD_BIT]))
        |-> (err_q == ($past(^word_i[CHK_W-1:0], 3) ^ $past(par_i, 2) ^ $past(par_pin_i))));

    // R5: flag holds when the load enable is high
    assert_hold_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_i[LOAD_BIT] |=> $stable(err_q));

    // R6: cascade output carries the previous word's sum and its parity bit
    assert_cascade_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2))
        |-> (par_pin_o == ($past(^word_i[CHK_W-1:0], 2) ^ $past(par_i))));

    // R7: pin not driven when configured as input
    assert_pin_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_i |-> !par_pin_oe_o);

    // R8: disabled output never pulls the line
    assert_line_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !err_pull_o);

endmodule

bind cascade_parity_chk cpc_checker #(
    .WORD_W(WORD_W), .CHK_W(CHK_W), .LOAD_BIT(LOAD_BIT)
) u_cpc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .oe_n_i       (oe_n_i),
    .word_i       (word_i),
    .par_i        (par_i),
    .par_oe_i     (par_oe_i),
    .par_pin_i    (par_pin_i),
    .par_pin_o    (par_pin_o),
    .par_pin_oe_o (par_pin_oe_o),
    .err_pull_o   (err_pull_o),
    .err_q        (err_q)
);

// File: tb/cascade_parity_chk_tb_top.sv
// Self-checking bench: seeded random stimulus plus directed corner cases,
// compared against a reference pipeline built from the requirements.
module cascade_parity_chk_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        oe_n_i = 1'b0;
    logic [11:0] word_i = '0;
    logic        par_i = 1'b0;
    logic        par_oe_i = 1'b1;
    logic        par_pin_i = 1'b0;
    logic        par_pin_o, par_pin_oe_o, err_pull_o;

    int n_vec = 0;
    int n_bad = 0;

    // reference pipeline state
    logic m_d1 = 1'b0, m_sum = 1'b0, m_par = 1'b0, m_err = 1'b0;

    always #2.5 clk = ~clk;

    cascade_parity_chk dut_i (
        .clk(clk), .rst_n(rst_n), .oe_n_i(oe_n_i), .word_i(word_i),
        .par_i(par_i), .par_oe_i(par_oe_i), .par_pin_i(par_pin_i),
        .par_pin_o(par_pin_o), .par_pin_oe_o(par_pin_oe_o), .err_pull_o(err_pull_o)
    );

    function automatic logic sum10(input logic [11:0] w);
        return ^w[9:0];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: update the reference at the edge, compare at the falling edge.
    task automatic tick(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_d1 = 0; m_sum = 0; m_par = 0; m_err = 0;
        end else begin
            if (!word_i[10]) m_err = m_sum ^ m_par ^ par_pin_i;
            m_sum = m_d1;
            m_par = par_i;
            m_d1  = sum10(word_i);
        end
        @(negedge clk);
        check(tag, err_pull_o, m_err & ~oe_n_i);
        check("R7 pin direction", par_pin_oe_o, ~par_oe_i);
        if (!par_oe_i) check("R6 cascade sum", par_pin_o, m_sum ^ m_par);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        tick("R1 reset");
        tick("R1 reset");
        rst_n = 1'b1;
        check("R1 released after reset", err_pull_o, 1'b0);

        // R2: bit 11 set, clean even word; must stay clean
        word_i = 12'h803; par_i = 0; par_pin_i = 0;
        tick("R2 bit11 excluded");
        word_i = 12'h800; par_i = 0;
        tick("R2 bit11 excluded");
        tick("R2 bit11 excluded");
        check("R2 no flag", err_pull_o, 1'b0);

        // R3/R4: mismatch, then odd sense via pin
        word_i = 12'h001; par_i = 0;
        tick("R3 delay");
        word_i = 12'h000; par_i = 0;
        tick("R3 delay");
        tick("R4 even mismatch");
        check("R4 flag set", err_pull_o, 1'b1);
        word_i = 12'h001; par_i = 0; par_pin_i = 1;
        tick("R4 odd");
        word_i = 12'h000;
        tick("R4 odd");
        tick("R4 odd clean");
        check("R4 odd sense clean", err_pull_o, 1'b0);
        par_pin_i = 0;

        // R5: mismatch arrives with load disabled, clean flag must survive
        word_i = 12'h003; tick("R5 setup");
        word_i = 12'h000; par_i = 1; tick("R5 setup");
        word_i = 12'h400; par_i = 0; tick("R5 hold");
        check("R5 flag held clean", err_pull_o, 1'b0);

        // R8: error loads while the line is disabled, appears when enabled
        oe_n_i = 1; word_i = 12'h007; tick("R8 off");
        word_i = 12'h000; par_i = 0; tick("R8 off");
        tick("R8 off");
        check("R8 line released", err_pull_o, 1'b0);
        oe_n_i = 0; word_i = 12'h400; tick("R9 shows stored error");
        check("R9 pulled low", err_pull_o, 1'b1);

        // R6: cascade first-device role
        par_oe_i = 0;
        for (int i = 0; i < 8; i++) begin
            word_i = 12'($urandom()) & 12'hBFF; par_i = 1'($urandom());
            tick("R6 cascade");
        end

        // random mix
        for (int i = 0; i < 2000; i++) begin
            word_i    = 12'($urandom());
            par_i     = 1'($urandom());
            par_pin_i = 1'($urandom());
            par_oe_i  = 1'($urandom());
            oe_n_i    = ($urandom() % 5) == 0;
            rst_n     = ($urandom() % 97) != 0;
            tick("R4 random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule